// File: doc/BRIEF.md
# Learning Address Lookup Table

This block is a small content-addressable table for the forwarding path of a network switch. Each received frame offers its source address and its ingress port on the learn request. The table either refreshes the port of an entry that already holds that address, or it appends the address at the next free slot. Each frame's destination address is offered on the lookup request. Every entry compares that key in parallel, and the registered result gives a hit flag, the index of the matching entry and the port stored with it.

The depth is a parameter, and each entry has its own comparators: one for lookups and one for learns. Because of this, a learn and a lookup can be accepted in the same cycle. Once every slot is in use, a full flag rises. Learns of new addresses are then refused, while learns of stored addresses still refresh their port. Only reset empties the table.

Top module: `addr_learn_cam`

## Requirements
- R1: While reset is asserted and right after its release, `hit`, `hit_idx`, `hit_port` and `full` are all 0, and a lookup of any address misses.
- R2: A learn of an address that is not stored writes it into the lowest free slot. Slots fill in learning order, starting at index 0. A later lookup of that address returns `hit`=1, that slot index and the learned port.
- R3: A lookup result appears on the outputs in the clock cycle after the request. In a cycle that follows a cycle with no lookup request, `hit` is 0.
- R4: On a miss, including a key that differs from a stored address in a single bit, `hit` is 0 and both `hit_idx` and `hit_port` are all zeros.
- R5: A learn of an address that is already stored rewrites only that entry's port, at the same index. It uses no new slot.
- R6: `full` becomes 1 in the cycle after the DEPTH-th distinct address is learned, and stays 1 until reset. While `full` is 1, a learn of a new address is dropped, so a later lookup of that address misses.
- R7: While `full` is 1, a learn of a stored address still updates that entry's port.
- R8: When a learn and a lookup of the same new address happen in the same cycle, the lookup sees the table as it was before the learn and misses. The next lookup hits.
- R9: A reset in the middle of operation clears every entry and the fill count, so addresses learned before it miss and `full` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| learn_vld | input | 1 | Learn request strobe |
| learn_key | input | KEY_W | Source address to learn |
| learn_port | input | PORT_W | Ingress port paired with the learned address |
| look_vld | input | 1 | Lookup request strobe |
| look_key | input | KEY_W | Destination address to search |
| hit | output | 1 | Registered: last cycle's lookup matched |
| hit_idx | output | IDX_W | Registered index of the matching entry, 0 on a miss |
| hit_port | output | PORT_W | Registered port of the matching entry, 0 on a miss |
| full | output | 1 | Every slot holds a valid address |

## Verification
The bench builds the table with DEPTH=4 and PORT_W=3 and keeps the full 48-bit key. With four slots, the full condition, refused appends and refreshes while full can all be reached after a handful of learns. At that depth the highest index (3) is also reached, and a key with a single flipped top bit shows that every key bit takes part in the compare. Same-cycle learn and lookup of one address, plus a reset in mid-run, cover the ordering and clearing rules.

// File: rtl/addr_cam_pkg.sv
package addr_cam_pkg;

  // What a learn request does to the table in its cycle.
  typedef enum logic [1:0] {
    LACT_IDLE    = 2'd0,
    LACT_REFRESH = 2'd1,
    LACT_APPEND  = 2'd2,
    LACT_DROP    = 2'd3
  } learn_act_e;

endpackage

// File: rtl/addr_cam_entry.sv
module addr_cam_entry #(
  parameter int KEY_W  = 48,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_new,
  input  logic              wr_port,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [PORT_W-1:0] port_in,
  input  logic [KEY_W-1:0]  look_key,
  input  logic [KEY_W-1:0]  learn_key,
  output logic              look_match,
  output logic              learn_match,
  output logic [PORT_W-1:0] port_out
);

  logic              vld_q, vld_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic              key_en, port_en;

  // Next-state logic
  always_comb begin
    vld_d   = vld_q | wr_new;
    key_en  = wr_new;
    port_en = wr_new | wr_port;
    key_d   = key_in;
    port_d  = port_in;
  end

  // Valid bit: reset so that empty slots never match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // Payload flops: no reset, explicit clock enables
  always_ff @(posedge clk) begin
    if (key_en)  key_q  <= key_d;
    if (port_en) port_q <= port_d;
  end

  // One comparator per request path
  assign look_match  = vld_q && (key_q == look_key);
  assign learn_match = vld_q && (key_q == learn_key);
  assign port_out    = port_q;

  // R2
  // entry_keeps_valid_chk
  entry_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> vld_q);

  // R2
  // entry_fills_chk
  entry_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_new |=> vld_q);

endmodule

// File: rtl/addr_cam_prio.sv
module addr_cam_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found) begin
      // R2
      // prio_points_at_match_chk
      prio_points_at_match_chk: assert (vec[idx]);
    end
  end

endmodule

// File: rtl/addr_learn_cam.sv
module addr_learn_cam #(
  parameter int DEPTH  = 8,
  parameter int KEY_W  = 48,
  parameter int PORT_W = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              learn_vld,
  input  logic [KEY_W-1:0]  learn_key,
  input  logic [PORT_W-1:0] learn_port,
  input  logic              look_vld,
  input  logic [KEY_W-1:0]  look_key,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [PORT_W-1:0] hit_port,
  output logic              full
);
  import addr_cam_pkg::*;

  // Reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DEPTH-1:0]  look_vec, learn_vec, wr_new, wr_port;
  logic [PORT_W-1:0] ent_port [DEPTH];
  logic              look_found, learn_found;
  logic [IDX_W-1:0]  look_sel, learn_sel;

  logic [CNT_W-1:0]  fill_q, fill_d;
  learn_act_e        act;

  // Storage with per-entry comparators
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    addr_cam_entry #(.KEY_W(KEY_W), .PORT_W(PORT_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_new     (wr_new[g]),
      .wr_port    (wr_port[g]),
      .key_in     (learn_key),
      .port_in    (learn_port),
      .look_key   (look_key),
      .learn_key  (learn_key),
      .look_match (look_vec[g]),
      .learn_match(learn_vec[g]),
      .port_out   (ent_port[g])
    );
  end

  addr_cam_prio #(.N(DEPTH), .IW(IDX_W)) u_look_prio (
    .vec  (look_vec),
    .found(look_found),
    .idx  (look_sel)
  );

  addr_cam_prio #(.N(DEPTH), .IW(IDX_W)) u_learn_prio (
    .vec  (learn_vec),
    .found(learn_found),
    .idx  (learn_sel)
  );

  assign full = (fill_q == CNT_W'(DEPTH));

  // Learn decision and write strobes
  always_comb begin
    if (!learn_vld)       act = LACT_IDLE;
    else if (learn_found) act = LACT_REFRESH;
    else if (full)        act = LACT_DROP;
    else                  act = LACT_APPEND;

    for (int i = 0; i < DEPTH; i++) begin
      wr_new[i]  = (act == LACT_APPEND)  && (fill_q == CNT_W'(i));
      wr_port[i] = (act == LACT_REFRESH) && (learn_sel == IDX_W'(i));
    end

    fill_d = (act == LACT_APPEND) ? fill_q + CNT_W'(1) : fill_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fill_q <= '0;
    else             fill_q <= fill_d;
  end

  // Lookup result, registered
  logic              hit_d;
  logic [IDX_W-1:0]  idx_d;
  logic [PORT_W-1:0] port_d;

  always_comb begin
    hit_d  = look_vld && look_found;
    idx_d  = hit_d ? look_sel : '0;
    port_d = hit_d ? ent_port[look_sel] : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit      <= 1'b0;
      hit_idx  <= '0;
      hit_port <= '0;
    end else begin
      hit      <= hit_d;
      hit_idx  <= idx_d;
      hit_port <= port_d;
    end
  end

  // R6
  // full_sticky_chk
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full |=> full);

  // R6
  // fill_bound_chk
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_q <= CNT_W'(DEPTH));

  // R3
  // idle_no_hit_chk
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !look_vld |=> !hit);

  // R4
  // miss_zero_chk
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |-> (hit_idx == '0 && hit_port == '0));

  // R5
  // no_duplicate_chk
  no_duplicate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(learn_vec));

  // R2
  // append_grows_chk
  append_grows_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (act == LACT_APPEND) |=> (fill_q == $past(fill_q) + CNT_W'(1)));

endmodule

// File: tb/addr_learn_cam_test.sv
module addr_learn_cam_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int KEY_W  = 48;
  localparam int PORT_W = 3;
  localparam int IDX_W  = 2;
  localparam int NVEC   = 15;

  localparam logic [KEY_W-1:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [KEY_W-1:0] MAC_B = 48'h0011_2233_4456;
  localparam logic [KEY_W-1:0] MAC_C = 48'hA0B0_C0D0_E0F0;
  localparam logic [KEY_W-1:0] MAC_D = 48'hFFFF_FFFF_FFFE;
  localparam logic [KEY_W-1:0] MAC_E = 48'h0200_0000_0001;

  typedef struct packed {
    logic [3:0]        req;
    logic              lrn;
    logic              lkp;
    logic [KEY_W-1:0]  mac;
    logic [PORT_W-1:0] prt;
    logic              e_hit;
    logic [IDX_W-1:0]  e_idx;
    logic [PORT_W-1:0] e_prt;
    logic              e_full;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd4, 1'b0, 1'b1, MAC_A, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0}, // R4 empty miss
    '{4'd2, 1'b1, 1'b0, MAC_A, 3'd1, 1'b0, 2'd0, 3'd0, 1'b0}, // R2 learn A
    '{4'd2, 1'b0, 1'b1, MAC_A, 3'd0, 1'b1, 2'd0, 3'd1, 1'b0}, // R2 hit A
    '{4'd8, 1'b1, 1'b1, MAC_B, 3'd2, 1'b0, 2'd0, 3'd0, 1'b0}, // R8 same-cycle
    '{4'd8, 1'b0, 1'b1, MAC_B, 3'd0, 1'b1, 2'd1, 3'd2, 1'b0}, // R8 then hits
    '{4'd5, 1'b1, 1'b0, MAC_A, 3'd5, 1'b0, 2'd0, 3'd0, 1'b0}, // R5 refresh A
    '{4'd5, 1'b0, 1'b1, MAC_A, 3'd0, 1'b1, 2'd0, 3'd5, 1'b0}, // R5 same index
    '{4'd5, 1'b1, 1'b0, MAC_C, 3'd3, 1'b0, 2'd0, 3'd0, 1'b0}, // R5 no slot used
    '{4'd6, 1'b1, 1'b0, MAC_D, 3'd4, 1'b0, 2'd0, 3'd0, 1'b1}, // R6 now full
    '{4'd6, 1'b1, 1'b0, MAC_E, 3'd6, 1'b0, 2'd0, 3'd0, 1'b1}, // R6 dropped
    '{4'd6, 1'b0, 1'b1, MAC_E, 3'd0, 1'b0, 2'd0, 3'd0, 1'b1}, // R6 E misses
    '{4'd2, 1'b0, 1'b1, MAC_D, 3'd0, 1'b1, 2'd3, 3'd4, 1'b1}, // R2 top index
    '{4'd7, 1'b1, 1'b0, MAC_B, 3'd7, 1'b0, 2'd0, 3'd0, 1'b1}, // R7 refresh full
    '{4'd7, 1'b0, 1'b1, MAC_B, 3'd0, 1'b1, 2'd1, 3'd7, 1'b1}, // R7 new port
    '{4'd2, 1'b0, 1'b1, MAC_C, 3'd0, 1'b1, 2'd2, 3'd3, 1'b1}  // R2 C intact
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              learn_vld, look_vld;
  logic [KEY_W-1:0]  learn_key, look_key;
  logic [PORT_W-1:0] learn_port;
  logic              hit, full;
  logic [IDX_W-1:0]  hit_idx;
  logic [PORT_W-1:0] hit_port;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_learn_cam #(.DEPTH(DEPTH), .KEY_W(KEY_W), .PORT_W(PORT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .learn_vld(learn_vld), .learn_key(learn_key), .learn_port(learn_port),
    .look_vld(look_vld), .look_key(look_key),
    .hit(hit), .hit_idx(hit_idx), .hit_port(hit_port), .full(full)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Drive at falling edge, let one rising edge pass, sample at the next fall.
  task automatic step(input logic lv, input logic kv, input logic [KEY_W-1:0] mac,
                      input logic [PORT_W-1:0] prt);
    learn_vld  = lv;
    learn_key  = mac;
    learn_port = prt;
    look_vld   = kv;
    look_key   = mac;
    @(posedge clk);
    @(negedge clk);
    learn_vld = 1'b0;
    look_vld  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 outputs held at zero during reset
    check("R1", "hit in reset", 64'(hit), 64'd0);
    check("R1", "full in reset", 64'(full), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    learn_vld = 1'b0; look_vld = 1'b0;
    learn_key = '0; look_key = '0; learn_port = '0;
    @(negedge clk);
    do_reset();

    // R1 state after release
    check("R1", "hit_idx", 64'(hit_idx), 64'd0);
    check("R1", "hit_port", 64'(hit_port), 64'd0);
    check("R1", "full", 64'(full), 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      step(VECS[v].lrn, VECS[v].lkp, VECS[v].mac, VECS[v].prt);
      check(tag, "full", 64'(full), 64'(VECS[v].e_full));
      if (VECS[v].lkp) begin
        check(tag, "hit", 64'(hit), 64'(VECS[v].e_hit));
        check(tag, "hit_idx", 64'(hit_idx), 64'(VECS[v].e_idx));
        check(tag, "hit_port", 64'(hit_port), 64'(VECS[v].e_prt));
      end
    end

    // R3: previous cycle hit C; an idle cycle must drop hit and clear fields
    step(1'b0, 1'b0, MAC_C, 3'd0);
    check("R3", "hit after idle", 64'(hit), 64'd0);
    check("R3", "port after idle", 64'(hit_port), 64'd0);

    // R4: single top-bit difference from A misses
    step(1'b0, 1'b1, MAC_A ^ (48'h1 << 47), 3'd0);
    check("R4", "hit near key", 64'(hit), 64'd0);
    check("R4", "idx near key", 64'(hit_idx), 64'd0);
    check("R4", "port near key", 64'(hit_port), 64'd0);

    // R3: result lands exactly one cycle after the request
    learn_vld = 1'b0; look_vld = 1'b1; look_key = MAC_D;
    #1;
    check("R3", "hit before edge", 64'(hit), 64'd0);
    @(posedge clk);
    @(negedge clk);
    look_vld = 1'b0;
    check("R3", "hit after edge", 64'(hit), 64'd1);
    check("R3", "idx after edge", 64'(hit_idx), 64'd3);

    // R9: reset mid-run empties the table
    do_reset();
    check("R9", "full cleared", 64'(full), 64'd0);
    step(1'b0, 1'b1, MAC_A, 3'd0);
    check("R9", "old A misses", 64'(hit), 64'd0);
    step(1'b0, 1'b1, MAC_D, 3'd0);
    check("R9", "old D misses", 64'(hit), 64'd0);

    // R2: refill starts from index 0 again
    step(1'b1, 1'b0, MAC_E, 3'd6);
    step(1'b0, 1'b1, MAC_E, 3'd0);
    check("R2", "refill hit", 64'(hit), 64'd1);
    check("R2", "refill idx", 64'(hit_idx), 64'd0);
    check("R2", "refill port", 64'(hit_port), 64'd6);

    finish_run();
  end

endmodule